// File: doc/BRIEF.md
# Four-Slot Pulse Position Symbol Decoder

This block is the receive-side decoder of a 13.56 MHz contactless link. It takes an active-high carrier-pause indication that is already synchronised to the carrier clock. In each 1024-cycle symbol it finds the one 256-cycle slot that holds a pause and turns that slot into a two-bit value. It packs four such values into a byte, with the first value received in the low bits.

A frame opens with a start pattern of two pauses. When the two pauses start 768 cycles apart, the frame is in four-slot mode and is decoded. The symbol grid then begins 256 cycles after the second pause starts. When the two pauses start 512 cycles apart, the frame belongs to the 256-slot mode. Such a frame is ignored and has no effect on the outputs. After it, the decoder waits for a quiet line before it looks for a new start pattern.

A symbol that does not fit the data coding ends the frame. At a byte boundary this is the normal end of the frame. Inside a byte it is an error, and the partial byte is dropped.

Top module: `ppm4_rx`

## Requirements
- R1: After synchronous reset, byte_valid_o, error_o and frame_active_o are all 0.
- R2: Two pause starts (pause rising edges) that lie 768 ±32 cycles apart open a four-slot frame. frame_active_o rises on the cycle after the second pause is sampled. Symbol 0 starts 256 cycles after the second pause starts.
- R3: In a symbol, a single pause that starts at offset 128 + 256·v (v = 0..3) from the symbol start decodes to the two-bit value v.
- R4: The value of the first symbol of a byte forms bits [1:0] of the byte and the value of the fourth symbol forms bits [7:6]. byte_o is updated and byte_valid_o pulses for one cycle at the end of the fourth symbol, 1024 cycles after that symbol starts.
- R5: A pause whose start is up to 32 cycles early or late against its nominal offset still decodes to the value of its slot.
- R6: If a symbol inside a byte (symbol 1, 2 or 3) has a pause that starts more than 32 cycles from every nominal offset, error_o pulses for one cycle at the end of that symbol. In the same cycle frame_active_o falls, and no byte is output.
- R7: If a symbol inside a byte has no pause or has two pauses, error_o pulses at the end of that symbol. frame_active_o falls and the partial byte is dropped.
- R8: If the first symbol of a byte is malformed (no pause, or a pause outside every window), the frame ends without error. frame_active_o falls at the end of that symbol.
- R9: Two pause starts that lie 512 ±32 cycles apart begin a 256-slot frame. That frame and its later pauses cause no byte_valid_o, no error_o and no frame_active_o. A new start pattern is only recognised once the line has had no pause start for IGNORE_QUIET cycles.
- R10: byte_valid_o and error_o are single-cycle pulses and are never high together. byte_valid_o is high only while frame_active_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst | input | 1 | Synchronous active-high reset |
| pause_i | input | 1 | Synchronised carrier-pause indication, high during a pause |
| byte_o | output | 8 | Last decoded byte, held until the next one |
| byte_valid_o | output | 1 | One-cycle strobe: byte_o carries a new byte |
| frame_active_o | output | 1 | High while a four-slot frame is being decoded |
| error_o | output | 1 | One-cycle strobe: a frame was abandoned inside a byte |

## Verification
Each symbol is judged at the clock edge at which its counter holds 1023. That edge comes 1023 cycles after the edge that samples the symbol's first cycle. byte_valid_o and error_o are therefore visible 1024 cycles after a symbol's drive starts, and frame_active_o changes on that same cycle at the end of a frame. frame_active_o also changes one cycle after the second start pause is sampled. The driver queues every expected byte and every expected error together with its due cycle. The monitor compares each strobe with the head of the queue by both value and cycle number, so a strobe that is early, late or not expected counts as a failure.

// File: rtl/ppm4_pkg.sv
package ppm4_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SOF,
    ST_FRAME,
    ST_IGNORE
  } ppm4_state_e;
endpackage

// File: rtl/ppm4_edge.sv
module ppm4_edge (
  input  logic clk,
  input  logic rst,
  input  logic pause_i,
  output logic rise_o
);
  logic pause_q;

  always_ff @(posedge clk) begin
    if (rst) pause_q <= 1'b0;
    else     pause_q <= pause_i;
  end

  assign rise_o = pause_i & ~pause_q;
endmodule

// File: rtl/ppm4_slot_classify.sv
module ppm4_slot_classify #(
  parameter int SLOT_CYC     = 256,
  parameter int TOL          = 32,
  parameter int BITS_PER_SYM = 2,
  localparam int SLOT_W      = $clog2(SLOT_CYC),
  localparam int POS_W       = SLOT_W + BITS_PER_SYM
) (
  input  logic [POS_W-1:0]        pos_i,
  output logic                    ok_o,
  output logic [BITS_PER_SYM-1:0] val_o
);
  localparam logic [SLOT_W-1:0] WIN_LO = SLOT_W'(SLOT_CYC/2 - TOL);
  localparam logic [SLOT_W-1:0] WIN_HI = SLOT_W'(SLOT_CYC/2 + TOL);

  logic [SLOT_W-1:0] off;

  assign off   = pos_i[SLOT_W-1:0];
  assign val_o = pos_i[POS_W-1:SLOT_W];
  assign ok_o  = (off >= WIN_LO) && (off <= WIN_HI);
endmodule

// File: rtl/ppm4_assemble.sv
module ppm4_assemble #(
  parameter int BITS_PER_SYM  = 2,
  parameter int SYMS_PER_BYTE = 4,
  localparam int W            = BITS_PER_SYM * SYMS_PER_BYTE
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    shift_i,
  input  logic                    last_i,
  input  logic [BITS_PER_SYM-1:0] val_i,
  output logic [W-1:0]            byte_o,
  output logic                    valid_o
);
  logic [W-1:0] sh;
  logic [W-1:0] sh_next;

  assign sh_next = {val_i, sh[W-1:BITS_PER_SYM]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (shift_i) begin
        sh <= sh_next;
        if (last_i) begin
          byte_o  <= sh_next;
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ppm4_rx.sv
module ppm4_rx
  import ppm4_pkg::*;
#(
  parameter int SLOT_CYC      = 256,
  parameter int TOL           = 32,
  parameter int BITS_PER_SYM  = 2,
  parameter int SYMS_PER_BYTE = 4,
  parameter int IGNORE_QUIET  = 140000,
  localparam int BYTE_W       = BITS_PER_SYM * SYMS_PER_BYTE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pause_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              frame_active_o,
  output logic              error_o
);
  localparam int SLOT_W     = $clog2(SLOT_CYC);
  localparam int POS_W      = SLOT_W + BITS_PER_SYM;
  localparam int SYM_CYC    = SLOT_CYC << BITS_PER_SYM;
  localparam int SOF4_GAP   = SYM_CYC - SLOT_CYC;
  localparam int SOF256_GAP = SYM_CYC / 2;
  localparam int GAP_MAX    = SYM_CYC + TOL;
  localparam int GAP_W      = $clog2(GAP_MAX + 1) + 1;
  localparam int QW         = $clog2(IGNORE_QUIET + 1);
  localparam int IDX_W      = (SYMS_PER_BYTE > 1) ? $clog2(SYMS_PER_BYTE) : 1;

  localparam logic [POS_W-1:0] POS_LAST = POS_W'(SYM_CYC - 1);
  localparam logic [POS_W-1:0] LEAD_POS = POS_W'(SYM_CYC - SLOT_CYC + 1);
  localparam logic [GAP_W-1:0] G4_LO    = GAP_W'(SOF4_GAP - TOL);
  localparam logic [GAP_W-1:0] G4_HI    = GAP_W'(SOF4_GAP + TOL);
  localparam logic [GAP_W-1:0] G256_LO  = GAP_W'(SOF256_GAP - TOL);
  localparam logic [GAP_W-1:0] G256_HI  = GAP_W'(SOF256_GAP + TOL);
  localparam logic [GAP_W-1:0] G_MAX    = GAP_W'(GAP_MAX);
  localparam logic [QW-1:0]    Q_LAST   = QW'(IGNORE_QUIET - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SYMS_PER_BYTE - 1);

  ppm4_state_e state;
  logic [GAP_W-1:0] gcnt;
  logic [QW-1:0] qcnt;
  logic [POS_W-1:0] pos;
  logic lead;
  logic [IDX_W-1:0] sidx;
  logic [1:0] pcnt;
  logic [BITS_PER_SYM-1:0] hold_val;
  logic hold_ok;

  logic rise;
  logic cls_ok;
  logic [BITS_PER_SYM-1:0] cls_val;
  logic first_ok;
  logic [BITS_PER_SYM-1:0] first_val;
  logic one_pause;
  logic sym_good;
  logic sym_end;
  logic in4, in256;

  ppm4_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .pause_i (pause_i),
    .rise_o  (rise)
  );

  ppm4_slot_classify #(
    .SLOT_CYC     (SLOT_CYC),
    .TOL          (TOL),
    .BITS_PER_SYM (BITS_PER_SYM)
  ) u_cls (
    .pos_i (pos),
    .ok_o  (cls_ok),
    .val_o (cls_val)
  );

  assign first_ok  = (pcnt == 2'd0) ? cls_ok  : hold_ok;
  assign first_val = (pcnt == 2'd0) ? cls_val : hold_val;
  assign one_pause = ((pcnt == 2'd0) && rise) || ((pcnt == 2'd1) && !rise);
  assign sym_good  = one_pause && first_ok;
  assign sym_end   = (state == ST_FRAME) && (pos == POS_LAST) && !lead;
  assign in4       = (gcnt >= G4_LO) && (gcnt <= G4_HI);
  assign in256     = (gcnt >= G256_LO) && (gcnt <= G256_HI);

  ppm4_assemble #(
    .BITS_PER_SYM  (BITS_PER_SYM),
    .SYMS_PER_BYTE (SYMS_PER_BYTE)
  ) u_asm (
    .clk     (clk),
    .rst     (rst),
    .shift_i (sym_end && sym_good),
    .last_i  (sidx == IDX_LAST),
    .val_i   (first_val),
    .byte_o  (byte_o),
    .valid_o (byte_valid_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      gcnt           <= '0;
      qcnt           <= '0;
      pos            <= '0;
      lead           <= 1'b0;
      sidx           <= '0;
      pcnt           <= '0;
      hold_val       <= '0;
      hold_ok        <= 1'b0;
      frame_active_o <= 1'b0;
      error_o        <= 1'b0;
    end else begin
      error_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (rise) begin
            state <= ST_SOF;
            gcnt  <= GAP_W'(1);
          end
        end
        ST_SOF: begin
          gcnt <= gcnt + 1'b1;
          if (rise) begin
            if (in4) begin
              state          <= ST_FRAME;
              frame_active_o <= 1'b1;
              pos            <= LEAD_POS;
              lead           <= 1'b1;
              sidx           <= '0;
              pcnt           <= '0;
            end else if (in256) begin
              state <= ST_IGNORE;
              qcnt  <= '0;
            end else begin
              gcnt <= GAP_W'(1);
            end
          end else if (gcnt >= G_MAX) begin
            state <= ST_IDLE;
          end
        end
        ST_FRAME: begin
          if (pos == POS_LAST) begin
            pos  <= '0;
            lead <= 1'b0;
            pcnt <= '0;
            if (!lead) begin
              if (sym_good) begin
                sidx <= (sidx == IDX_LAST) ? '0 : sidx + 1'b1;
              end else begin
                state          <= ST_IDLE;
                frame_active_o <= 1'b0;
                error_o        <= (sidx != '0);
              end
            end
          end else begin
            pos <= pos + 1'b1;
            if (rise && !lead) begin
              if (pcnt == 2'd0) begin
                hold_val <= cls_val;
                hold_ok  <= cls_ok;
              end
              if (pcnt != 2'd2) pcnt <= pcnt + 1'b1;
            end
          end
        end
        ST_IGNORE: begin
          if (rise)                 qcnt  <= '0;
          else if (qcnt == Q_LAST)  state <= ST_IDLE;
          else                      qcnt  <= qcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ppm4_rx_chk.sv
module ppm4_rx_chk (
  input logic clk,
  input logic rst,
  input logic byte_valid_o,
  input logic frame_active_o,
  input logic error_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!byte_valid_o && !error_o && !frame_active_o));

  // R10
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(byte_valid_o && error_o));

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |=> !byte_valid_o);

  // R10
  error_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    error_o |=> !error_o);

  // R10
  valid_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |-> frame_active_o);

  // R6
  error_ends_frame_chk: assert property (@(posedge clk) disable iff (rst)
    error_o |-> (!frame_active_o && $past(frame_active_o)));
endmodule

bind ppm4_rx ppm4_rx_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .byte_valid_o   (byte_valid_o),
  .frame_active_o (frame_active_o),
  .error_o        (error_o)
);

// File: tb/tb_ppm4_rx.sv
module tb_ppm4_rx;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 190000;
  localparam int QUIET      = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pause_i = 1'b0;
  logic [7:0] byte_o;
  logic byte_valid_o, frame_active_o, error_o;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int exp_byte_q[$];
  int exp_byte_t[$];
  int exp_err_t[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ppm4_rx #(.IGNORE_QUIET(QUIET)) dut (
    .clk            (clk),
    .rst            (rst),
    .pause_i        (pause_i),
    .byte_o         (byte_o),
    .byte_valid_o   (byte_valid_o),
    .frame_active_o (frame_active_o),
    .error_o        (error_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at cycle %0d",
               req, act, act, exp, exp, cyc);
    end
  endtask

  task automatic drive(bit v, int n);
    pause_i = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic sof4();
    drive(1, 128); drive(0, 640); drive(1, 128); drive(0, 128);
  endtask

  // one symbol: pause for value v, shifted by d cycles
  task automatic symbol(int v, int d);
    drive(0, 128 + 256*v + d); drive(1, 128); drive(0, 768 - 256*v - d);
  endtask

  task automatic empty_symbol();
    drive(0, 1024);
  endtask

  task automatic send_byte(int b, int d0, int d1, int d2, int d3);
    int d[4];
    d = '{d0, d1, d2, d3};
    for (int k = 0; k < 4; k++) begin
      if (k == 3) begin
        exp_byte_q.push_back(b);
        exp_byte_t.push_back(cyc + 1024);
      end
      symbol((b >> (2*k)) & 3, d[k]);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (byte_valid_o) begin
        if (exp_byte_q.size() == 0) chk(0, "R4 unexpected byte", int'(byte_o), -1);
        else begin
          int eb, et;
          eb = exp_byte_q.pop_front();
          et = exp_byte_t.pop_front();
          chk(int'(byte_o) == eb, "R4 byte value (R3 R5)", int'(byte_o), eb);
          chk(cyc == et, "R4 byte strobe cycle", cyc, et);
        end
      end
      if (error_o) begin
        if (exp_err_t.size() == 0) chk(0, "R8 R9 unexpected error", cyc, -1);
        else begin
          int et;
          et = exp_err_t.pop_front();
          chk(cyc == et, "R6 R7 error strobe cycle", cyc, et);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == WD_LIMIT && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1
    chk(byte_valid_o == 0 && error_o == 0 && frame_active_o == 0,
        "R1 outputs after reset", {byte_valid_o, error_o, frame_active_o}, 0);
    rst = 1'b0;
    drive(0, 200);

    // R2 R3 R4: clean frame, then end at byte boundary (R8)
    sof4();
    chk(frame_active_o == 1, "R2 frame active after start", frame_active_o, 1);
    send_byte(8'hE1, 0, 0, 0, 0);
    send_byte(8'h00, 0, 0, 0, 0);
    send_byte(8'hFF, 0, 0, 0, 0);
    send_byte(8'h5A, 0, 0, 0, 0);
    chk(frame_active_o == 1, "R2 frame still active", frame_active_o, 1);
    empty_symbol();
    chk(frame_active_o == 0, "R8 empty symbol at boundary ends frame", frame_active_o, 0);
    drive(0, 2000);

    // R5: edges of the tolerance window
    sof4();
    send_byte(8'h93, -32, 32, -32, 32);
    send_byte(8'h0F, 0, 0, 0, 0);
    // R8: pause outside every window at byte boundary
    drive(1, 128); drive(0, 896);
    chk(frame_active_o == 0, "R8 bad pause at boundary ends frame", frame_active_o, 0);
    drive(0, 2000);

    // R6: late by 33 in symbol 1
    sof4();
    symbol(0, 0);
    exp_err_t.push_back(cyc + 1024);
    symbol(1, 33);
    chk(frame_active_o == 0, "R6 late pause ends frame", frame_active_o, 0);
    drive(0, 3000);

    // R6: early by 33 in symbol 2
    sof4();
    symbol(3, 0); symbol(2, 0);
    exp_err_t.push_back(cyc + 1024);
    symbol(2, -33);
    chk(frame_active_o == 0, "R6 early pause ends frame", frame_active_o, 0);
    drive(0, 3000);

    // R7: two pauses in symbol 1
    sof4();
    symbol(1, 0);
    exp_err_t.push_back(cyc + 1024);
    drive(0, 128); drive(1, 128); drive(0, 256); drive(1, 128); drive(0, 384);
    chk(frame_active_o == 0, "R7 double pause ends frame", frame_active_o, 0);
    drive(0, 3000);

    // R7: no pause in symbol 3
    sof4();
    symbol(1, 0); symbol(2, 0); symbol(3, 0);
    exp_err_t.push_back(cyc + 1024);
    empty_symbol();
    chk(frame_active_o == 0, "R7 missing pause ends frame", frame_active_o, 0);
    drive(0, 3000);

    // R9: 256-slot start pattern, following data-like pauses ignored
    drive(1, 128); drive(0, 384); drive(1, 128); drive(0, 384);
    chk(frame_active_o == 0, "R9 ignored frame not active", frame_active_o, 0);
    sof4();
    chk(frame_active_o == 0, "R9 start inside ignored frame", frame_active_o, 0);
    symbol(1, 0); symbol(2, 0); symbol(3, 0); symbol(0, 0);
    chk(frame_active_o == 0, "R9 still not active", frame_active_o, 0);
    drive(0, QUIET + 200);
    sof4();
    chk(frame_active_o == 1, "R9 new frame after quiet", frame_active_o, 1);
    send_byte(8'h3C, 0, 0, 0, 0);
    empty_symbol();
    drive(0, 100);

    chk(exp_byte_q.size() == 0, "R4 all bytes seen", exp_byte_q.size(), 0);
    chk(exp_err_t.size() == 0, "R10 all errors seen", exp_err_t.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule